// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block is a bus master sequencer. It accepts one operand request (a byte address, a length of one to four bytes and a read or write flag) and runs as many external bus cycles as the responding port needs to move that operand. Each cycle opens as a full-width 32-bit attempt. The slave then ends it in one of two ways: a two-bit active-low width acknowledge that reports an 8-, 16- or 32-bit port, or a synchronous termination strobe that always means a 32-bit port. The controller works out how many bytes that cycle carried, moves the address and the remaining-byte count forward, and starts the next cycle until the operand is complete.

Write bytes are copied onto several lanes, so that a port of any width finds its bytes on the lanes it is wired to. Read bytes are taken from the lanes of the reporting port and packed into a right-justified result. Unaligned operands are split at port boundaries, which gives the fewest possible cycles. Wait states come from a late termination. A bus error ends the operand with an error flag, and a bus error together with halt repeats the current cycle.

Top module: `dbs_ctrl`

## Requirements
- R1: After synchronous reset the controller is idle: req_ready is 1, and bus_cyc, bus_start and done are 0.
- R2: ack_n is active low. 2'b00 reports a 32-bit port, 2'b01 reports a 16-bit port, 2'b10 reports an 8-bit port, and 2'b11 means no acknowledge (wait). sterm ends a cycle as a 32-bit port and takes priority over ack_n.
- R3: With a address offset a = addr[1:0] and n bytes remaining, one cycle carries min(n, 4-a) bytes on a 32-bit port, min(n, 2-a[0]) bytes on a 16-bit port and 1 byte on an 8-bit port. An operand therefore needs the minimum number of cycles at any alignment.
- R4: bus_start is high in the first clock of every bus cycle, and only while bus_cyc is high. Throughout a cycle, bus_addr holds the address of the next byte and bus_size holds the remaining count (00 = four, 01 = one, 10 = two, 11 = three). Both are stable within a cycle and move forward between cycles.
- R5: ack_n is honoured only from the third clock of a cycle. An asynchronous cycle therefore lasts max(3, d+1) clocks when the acknowledge first appears in clock d+1. An earlier acknowledge is ignored.
- R6: sterm and berr are honoured from the second clock of a cycle. A synchronous cycle therefore lasts at least two clocks, and each later clock of sterm adds one.
- R7: Lane k is bus bits 31-8k down to 24-8k. An 8-bit port uses lane 0, a 16-bit port uses lanes 0-1 (at offset addr[0]), and a 32-bit port uses lane addr[1:0]. Read data is right-justified in rdata, with the lowest-addressed byte most significant.
- R8: Write data is right-justified in req_wdata. In every cycle, each byte the port takes is found on the lane that R7 gives for that port width and address.
- R9: berr without halt, once honoured, ends the operand: done and err are high in the next clock and rdata is 0. berr takes priority over sterm and ack_n.
- R10: berr with halt, once honoured, restarts the same cycle: bus_start pulses in the next clock with bus_addr and bus_size unchanged, and the operand result is unaffected.
- R11: done is a one-clock pulse that appears only after the final cycle ends, in the clock after that terminating edge, with the controller back to idle. rdata holds the assembled read (0 for writes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand request, taken when req_ready is high |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand length, 00 = four bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Right-justified write operand |
| req_ready | output | 1 | Idle, can take a request |
| done | output | 1 | Operand finished pulse |
| err | output | 1 | Operand aborted by bus error (with done) |
| rdata | output | DATA_W | Assembled read operand |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_start | output | 1 | First clock of a bus cycle |
| bus_addr | output | ADDR_W | Cycle address |
| bus_size | output | 2 | Remaining byte count |
| bus_write | output | 1 | Cycle direction |
| bus_wdata | output | DATA_W | Steered write lanes |
| bus_rdata | input | DATA_W | Read lanes from the slave |
| ack_n | input | 2 | Active-low port width acknowledge |
| sterm | input | 1 | Synchronous 32-bit termination |
| berr | input | 1 | Bus error |
| halt | input | 1 | With berr, requests a retry |

## Verification
The result of each operand is due a fixed number of clocks after the request edge. That number is the sum of the lengths of its cycles: max(w,2)+1 for an asynchronous cycle and max(w,1)+1 for a synchronous one, where w is the slave's chosen delay, plus one sync-length cycle for each retry. The driver computes this sum from the requirements and queues it with the expected data and error flag. The monitor samples done at falling edges and compares the measured clock distance, so a result that arrives early or late fails. The bench's slave model also checks bus_addr and bus_size at each bus_start, and write checks read back the bytes that the slave stored from the lanes of its port width.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {PW_8 = 2'd0, PW_16 = 2'd1, PW_32 = 2'd2} port_w_t;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} ctl_state_t;
endpackage

// File: rtl/dbs_term_decode.sv
module dbs_term_decode #(
  parameter int CNT_W     = 4,
  parameter int ASYNC_MIN = 3,
  parameter int SYNC_MIN  = 2
) (
  input  logic              run,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [1:0]        ack_n,
  input  logic              sterm,
  input  logic              berr,
  input  logic              halt,
  output logic              fin,
  output dbs_pkg::port_w_t  port,
  output logic              abort,
  output logic              retry
);
  import dbs_pkg::*;
  localparam logic [CNT_W-1:0] SYNC_CNT  = CNT_W'(SYNC_MIN - 1);
  localparam logic [CNT_W-1:0] ASYNC_CNT = CNT_W'(ASYNC_MIN - 1);

  logic sync_win, async_win, sterm_hit, ack_hit;

  always_comb begin
    sync_win  = run && (cnt >= SYNC_CNT);
    async_win = run && (cnt >= ASYNC_CNT);
    retry     = sync_win && berr && halt;
    abort     = sync_win && berr && !halt;
    sterm_hit = sync_win && sterm && !berr;
    ack_hit   = async_win && (ack_n != 2'b11) && !berr;
    fin       = sterm_hit || ack_hit;
    if (sterm_hit) port = PW_32;
    else begin
      case (ack_n)
        2'b00:   port = PW_32;
        2'b01:   port = PW_16;
        default: port = PW_8;
      endcase
    end
  end
endmodule

// File: rtl/dbs_lane_calc.sv
module dbs_lane_calc #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        addr_lo,
  input  logic [2:0]        rem,
  input  dbs_pkg::port_w_t  port,
  input  logic [DATA_W-1:0] pend,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] rd_lanes,
  output logic [2:0]        take,
  output logic [DATA_W-1:0] acc_next,
  output logic [DATA_W-1:0] wr_lanes
);
  import dbs_pkg::*;
  localparam int LANES = DATA_W / 8;

  logic [2:0]        room;
  logic [1:0]        first_lane;
  logic [DATA_W-1:0] aligned;

  always_comb begin
    case (port)
      PW_32:   begin room = 3'd4 - {1'b0, addr_lo};     first_lane = addr_lo; end
      PW_16:   begin room = 3'd2 - {2'b0, addr_lo[0]};  first_lane = {1'b0, addr_lo[0]}; end
      default: begin room = 3'd1;                       first_lane = 2'd0; end
    endcase
    take     = (rem < room) ? rem : room;
    aligned  = rd_lanes << {1'b0, first_lane, 3'b000};
    acc_next = (acc << {take, 3'b000}) | (aligned >> (6'd32 - {take, 3'b000}));
  end

  // each lane carries the pending byte that any port width would expect there
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [1:0] src;
    always_comb begin
      case (addr_lo)
        2'd0:    src = 2'(j);
        2'd1:    src = (j == 0) ? 2'd0 : 2'(j - 1);
        2'd2:    src = {1'b0, 1'(j % 2)};
        default: src = 2'd0;
      endcase
      wr_lanes[DATA_W-1-8*j -: 8] = pend[DATA_W-1-8*src -: 8];
    end
  end
endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 4,
  parameter int ASYNC_MIN = 3,
  parameter int SYNC_MIN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_cyc,
  output logic              bus_start,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        ack_n,
  input  logic              sterm,
  input  logic              berr,
  input  logic              halt
);
  import dbs_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctl_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        rem;
  logic [DATA_W-1:0] pend, acc, acc_next;
  logic [2:0]        take, req_n;
  logic              fin, abort, retry;
  port_w_t           port;

  dbs_term_decode #(.CNT_W(CNT_W), .ASYNC_MIN(ASYNC_MIN), .SYNC_MIN(SYNC_MIN)) u_term (
    .run(state == ST_RUN), .cnt(cnt), .ack_n(ack_n), .sterm(sterm),
    .berr(berr), .halt(halt), .fin(fin), .port(port), .abort(abort), .retry(retry));

  dbs_lane_calc #(.DATA_W(DATA_W)) u_lane (
    .addr_lo(bus_addr[1:0]), .rem(rem), .port(port), .pend(pend), .acc(acc),
    .rd_lanes(bus_rdata), .take(take), .acc_next(acc_next), .wr_lanes(bus_wdata));

  assign req_n     = (req_size == 2'b00) ? 3'd4 : {1'b0, req_size};
  assign req_ready = (state == ST_IDLE);
  assign bus_cyc   = (state == ST_RUN);
  assign bus_size  = rem[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rem       <= 3'd4;
      pend      <= '0;
      acc       <= '0;
      bus_addr  <= '0;
      bus_write <= 1'b0;
      bus_start <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
    end else begin
      done      <= 1'b0;
      err       <= 1'b0;
      bus_start <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          state     <= ST_RUN;
          bus_addr  <= req_addr;
          rem       <= req_n;
          bus_write <= req_write;
          pend      <= req_wdata << {3'd4 - req_n, 3'b000};
          acc       <= '0;
          cnt       <= '0;
          bus_start <= 1'b1;
        end
        default: begin
          if (retry) begin
            cnt       <= '0;
            bus_start <= 1'b1;
          end else if (abort) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            err   <= 1'b1;
            rdata <= '0;
          end else if (fin) begin
            if (take == rem) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              rdata <= bus_write ? '0 : acc_next;
            end else begin
              bus_addr  <= bus_addr + ADDR_W'(take);
              rem       <= rem - take;
              pend      <= pend << {take, 3'b000};
              acc       <= acc_next;
              cnt       <= '0;
              bus_start <= 1'b1;
            end
          end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dbs_ctrl_chk.sv
module dbs_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              done,
  input logic              err,
  input logic              bus_cyc,
  input logic              bus_start,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              sterm,
  input logic              berr,
  input logic              halt
);
  p_start_in_cyc_r4: assert property (@(posedge clk) disable iff (rst)
    bus_start |-> bus_cyc);
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_start) |-> ($stable(bus_addr) && $stable(bus_size)));
  p_sync_min_r6: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> (!bus_start && !done));
  p_async_min_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_start ##1 (!sterm && !berr)) |=> (!bus_start && !done));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_ready && !bus_cyc));
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_start && berr && !halt) |=> (done && err));
  p_retry_same_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_start && berr && halt) |=>
      (bus_start && $stable(bus_addr) && $stable(bus_size)));
endmodule

bind dbs_ctrl dbs_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .done(done), .err(err),
  .bus_cyc(bus_cyc), .bus_start(bus_start), .bus_addr(bus_addr),
  .bus_size(bus_size), .sterm(sterm), .berr(berr), .halt(halt));

// File: tb/tb_dbs_ctrl.sv
module tb_dbs_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready, done, err, bus_cyc, bus_start, bus_write;
  logic [31:0] rdata, bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic [1:0]  bus_size;
  logic [1:0]  ack_n = 2'b11;
  logic        sterm = 1'b0, berr = 1'b0, halt = 1'b0;

  int checks = 0, errors = 0;
  int tcyc = 0, t0 = 0;
  logic [7:0] mem [64];

  // slave configuration: port 0=8 bit, 1=16 bit, 2=32 async, 3=32 sync
  int sport = 2, swait = 2, emode = 0;
  int scnt = 0, pend_t = 0, exp_rem = 0;
  logic [31:0] exp_addr = '0;
  bit retry_pend = 0, retried = 0;

  typedef struct { logic [31:0] rd; logic er; int lat; string tag; } exp_t;
  exp_t q[$];

  dbs_ctrl dut (.*);

  always #5 clk = ~clk;
  initial forever begin @(posedge clk); tcyc++; end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int take_of(input int port, input int a, input int n);
    int room;
    room = (port == 0) ? 1 : (port == 1) ? 2 - (a % 2) : 4 - (a % 4);
    return (n < room) ? n : room;
  endfunction

  function automatic int len_of(input int port, input int w);
    int lim;
    lim = (port == 3) ? 1 : 2;
    return ((w > lim) ? w : lim) + 1;
  endfunction

  // slave model
  initial forever begin
    @(negedge clk);
    if (!bus_cyc) begin
      ack_n = 2'b11; sterm = 0; berr = 0; halt = 0;
    end else begin
      if (bus_start) begin
        scnt = 0;
        if (retry_pend) begin retry_pend = 0; retried = 1; end
        else begin exp_addr += pend_t; exp_rem -= pend_t; pend_t = 0; end
        check(bus_addr == exp_addr, "R4", "bus_addr", bus_addr, exp_addr);
        check(bus_size == 2'(exp_rem), "R4", "bus_size", bus_size, 2'(exp_rem));
        ack_n = 2'b11; sterm = 0; berr = 0; halt = 0;
      end else scnt++;
      for (int j = 0; j < 4; j++) begin
        int a, src;
        a = int'(bus_addr[5:0]);
        if (sport >= 2) src = (a & ~3) + j;
        else if (sport == 1) src = (j < 2) ? (a & ~1) + j : -1;
        else src = (j == 0) ? a : -1;
        bus_rdata[31-8*j -: 8] = (src < 0) ? 8'h5A : mem[src % 64];
      end
      if (scnt >= swait) begin
        if (emode == 1) berr = 1;
        else if (emode == 2 && !retried) begin berr = 1; halt = 1; retry_pend = 1; end
        else begin
          int a, n, t, lane0;
          a = int'(bus_addr[5:0]);
          n = (bus_size == 2'b00) ? 4 : int'(bus_size);
          t = take_of(sport, a, n);
          lane0 = (sport >= 2) ? a % 4 : (sport == 1) ? a % 2 : 0;
          if (sport == 3) sterm = 1;
          else ack_n = (sport == 2) ? 2'b00 : (sport == 1) ? 2'b01 : 2'b10;
          pend_t = t;
          if (bus_write)
            for (int i = 0; i < t; i++)
              mem[(a + i) % 64] = bus_wdata[31-8*(lane0+i) -: 8];
        end
      end
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (!rst && done) begin
      if (q.size() == 0) check(0, "R11", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(rdata == e.rd, e.tag, "rdata", rdata, e.rd);
        check(err == e.er, e.tag, "err", err, e.er);
        check(tcyc - t0 == e.lat, e.tag, "latency", tcyc - t0, e.lat);
      end
    end
  end

  task automatic run_op(input int a, input int n, input bit wr, input logic [31:0] wd,
                        input int port, input int w, input int em, input string tag);
    exp_t e;
    int aa, nn, t;
    sport = port; swait = w; emode = em;
    exp_addr = 32'(a); exp_rem = n; pend_t = 0; retried = 0; retry_pend = 0;
    e.rd = '0; e.er = (em == 1); e.lat = 0; e.tag = tag;
    if (em == 1) e.lat = len_of(3, w);
    else begin
      if (em == 2) e.lat = len_of(3, w);
      aa = a; nn = n;
      while (nn > 0) begin
        t = take_of(port, aa, nn);
        e.lat += len_of(port, w);
        aa += t; nn -= t;
      end
      if (!wr) for (int i = 0; i < n; i++) e.rd = (e.rd << 8) | 32'(mem[(a + i) % 64]);
    end
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = 32'(a); req_size = 2'(n); req_write = wr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    t0 = tcyc; req_valid = 0;
    while (q.size() != 0) @(negedge clk);
    if (wr && em == 0)
      for (int i = 0; i < n; i++)
        check(mem[(a + i) % 64] == wd[8*(n-1-i) +: 8], "R8", "written byte",
              mem[(a + i) % 64], wd[8*(n-1-i) +: 8]);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(8'h11 + i * 7);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready && !bus_cyc && !bus_start && !done, "R1", "reset idle",
          {req_ready, bus_cyc, bus_start, done}, 4'b1000);
    run_op(8, 4, 0, 0, 2, 2, 0, "R2 long read 32-bit port");
    run_op(8, 4, 0, 0, 1, 2, 0, "R3 long read 16-bit port");
    run_op(12, 4, 0, 0, 0, 2, 0, "R3 long read 8-bit port");
    run_op(17, 4, 0, 0, 2, 2, 0, "R3 R7 misaligned long 32-bit");
    run_op(23, 2, 0, 0, 1, 2, 0, "R3 R7 odd word 16-bit");
    run_op(27, 1, 0, 0, 2, 2, 0, "R7 byte lane3");
    run_op(30, 3, 0, 0, 2, 3, 0, "R3 three bytes across boundary");
    run_op(4, 4, 0, 0, 3, 0, 0, "R6 sync zero wait");
    run_op(5, 4, 0, 0, 3, 3, 0, "R6 sync three waits");
    run_op(40, 4, 0, 0, 2, 0, 0, "R5 early ack ignored");
    run_op(40, 2, 0, 0, 2, 5, 0, "R5 async wait states");
    run_op(42, 4, 1, 32'hA1B2C3D4, 0, 2, 0, "R8 long write 8-bit");
    run_op(49, 3, 1, 32'h00E5F607, 2, 2, 0, "R8 three-byte write 32-bit");
    run_op(51, 2, 1, 32'h00009A8B, 1, 2, 0, "R8 word write 16-bit odd");
    run_op(53, 4, 0, 0, 2, 2, 1, "R9 bus error abort");
    run_op(53, 4, 0, 0, 1, 1, 2, "R10 retry then 16-bit");
    run_op(42, 4, 0, 0, 3, 1, 0, "R11 read back written");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule